// File: doc/BRIEF.md
# Pseudo-DMA Word Data Port

This block is the host-side data window of a SCSI controller's byte-wide FIFOs. A processor that has no real DMA engine moves a transfer by issuing plain bus reads and writes to this window. Each bus access, 8 or 16 bits wide, is taken as one request on a valid/ready channel. The block splits it into single-byte pushes or pops on the selected FIFO, one byte per cycle. Each byte written counts down the controller's transfer counter. After the last byte of an access, the block decides whether the host burst must stop.

The FIFOs themselves are outside the block. The block sees each FIFO through a push strobe, a pop strobe, the head byte and its used and free counts. While `cmd_mode` is high, all traffic goes to the command FIFO instead of the data FIFO. The counter lives in this block: the register file loads it and clears its terminal-count flag, and the block shows its value. The data-request line `drq` is a separate output. It has its own raise and lower inputs, and a burst-complete event also drops it.

Back-pressure rules: a request is accepted only in a cycle where `req_ready` is high, and the block takes no new request until the access it holds is fully finished. A read answer is held on `rsp_valid`/`rsp_data`, unchanged, until `rsp_ready` is seen high. Writes produce no answer.

Top module: `pdma_port`

## Requirements
- R1: A 16-bit write pushes `req_wdata[15:8]` in the first move cycle and `req_wdata[7:0]` in the next cycle.
- R2: A 16-bit read pops two bytes. The first byte popped becomes `rsp_data[15:8]` and the second becomes `rsp_data[7:0]`.
- R3: Every byte of a write lowers `tc_count` by one while it is non-zero. Reads never change `tc_count`. `tc_load` replaces the value.
- R4: A written byte that arrives while `tc_count` is zero is discarded: no push is issued and both FIFOs are unchanged.
- R5: `tc_flag` goes high at the same clock edge at which a write brings `tc_count` from 1 to 0. It stays high until `tc_flag_clr` is pulsed.
- R6: In the cycle after the last byte of a write, `burst_done` pulses for one cycle if `tc_count` is zero or the data FIFO has fewer than 2 free entries.
- R7: In the cycle after the last byte of a read, `burst_done` pulses for one cycle if the data FIFO holds fewer than 2 bytes.
- R8: While `cmd_mode` is 1, pushes and pops go to the command FIFO only. The end-of-burst tests of R6 and R7 still look at the data FIFO.
- R9: `req_size` holds the access width minus one. A value of 0 is a byte access: it uses `req_wdata[7:0]` and returns `{8'h00, byte}`. The values 1, 2 and 3 (2, 3 and 4 bytes) are all handled as a 16-bit access on bits 15:0.
- R10: `drq` goes high one cycle after `drq_raise`. It goes low after `drq_lower` or after a `burst_done` pulse.
- R11: `req_ready` is high only when no access is in progress. A read answer stays valid with stable data until `rsp_ready` is high.
- R12: A pop from an empty FIFO is not issued and returns byte 0x00. A push into a full FIFO is not issued, but the counter still counts that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host access request valid |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access bytes minus one |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read answer valid |
| rsp_ready | input | 1 | Host takes the read answer |
| rsp_data | output | 16 | Read answer |
| cmd_mode | input | 1 | Route traffic to the command FIFO |
| dat_push | output | 1 | Push strobe, data FIFO |
| cmd_push | output | 1 | Push strobe, command FIFO |
| push_byte | output | 8 | Byte to push |
| dat_pop | output | 1 | Pop strobe, data FIFO |
| cmd_pop | output | 1 | Pop strobe, command FIFO |
| dat_head | input | 8 | Head byte, data FIFO |
| dat_used | input | DAT_UW | Bytes held, data FIFO |
| dat_free | input | DAT_UW | Free entries, data FIFO |
| cmd_head | input | 8 | Head byte, command FIFO |
| cmd_used | input | CMD_UW | Bytes held, command FIFO |
| cmd_free | input | CMD_UW | Free entries, command FIFO |
| tc_load | input | 1 | Load the transfer counter |
| tc_load_val | input | TC_W | Value to load |
| tc_flag_clr | input | 1 | Clear the terminal-count flag |
| tc_count | output | TC_W | Transfer counter value |
| tc_flag | output | 1 | Terminal-count flag |
| drq_raise | input | 1 | Raise the data request |
| drq_lower | input | 1 | Lower the data request |
| drq | output | 1 | Data request line |
| burst_done | output | 1 | End-of-burst pulse |

## Verification
The bench goes after several corner cases, and each has a typical fault:
- **Byte order of wide accesses.** A swapped split or swapped assembly would show byte-reversed FIFO contents or read answers.
- **Write with the counter at zero.** A design that lets the byte through would grow the FIFO or wrap the counter to all ones.
- **FIFO edges: full, nearly full, empty.** A design that pushes into a full FIFO or pops an empty one would corrupt the queue. A design that tests "free < 2" with the wrong bound would end a burst one access early or late.
- **Command mode.** A design that also tests the end condition on the command FIFO would pulse `burst_done` with the wrong timing.
- **Held read answer.** Without `rsp_ready`, a design that drops or changes the answer, or accepts a new request early, is caught.

// File: rtl/pdma_pkg.sv
`timescale 1ns/1ps
package pdma_pkg;

  // Sequencer phases: take a request, move bytes, judge the burst, answer
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_MOVE  = 2'd1,
    PH_EVAL  = 2'd2,
    PH_REPLY = 2'd3
  } pdma_phase_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;

  // Any width above one byte is handled as a 16-bit access
  function automatic logic size_is_wide(input logic [1:0] sz);
    return sz != SZ_BYTE;
  endfunction

endpackage

// File: rtl/pdma_seq.sv
`timescale 1ns/1ps
module pdma_seq
  import pdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [1:0]  req_size,
  input  logic [15:0] req_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [15:0] rsp_data,
  output logic        mv_wr,
  output logic        mv_rd,
  output logic [7:0]  mv_byte,
  input  logic [7:0]  rd_byte,
  output logic        at_eval,
  output logic        eval_write
);

  pdma_phase_e phase_q;
  logic        op_wr_q;
  logic        op_wide_q;
  logic        hi_done_q;
  logic [15:0] wbuf_q;
  logic [15:0] rbuf_q;
  logic        first_of_two;

  // High byte travels first on a wide access
  assign first_of_two = op_wide_q && !hi_done_q;

  always_comb begin
    req_ready  = (phase_q == PH_IDLE);
    mv_wr      = (phase_q == PH_MOVE) && op_wr_q;
    mv_rd      = (phase_q == PH_MOVE) && !op_wr_q;
    mv_byte    = first_of_two ? wbuf_q[15:8] : wbuf_q[7:0];
    at_eval    = (phase_q == PH_EVAL);
    eval_write = op_wr_q;
    rsp_valid  = (phase_q == PH_REPLY);
    rsp_data   = rbuf_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      op_wr_q   <= 1'b0;
      op_wide_q <= 1'b0;
      hi_done_q <= 1'b0;
      wbuf_q    <= '0;
      rbuf_q    <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (req_valid) begin
            op_wr_q   <= req_write;
            op_wide_q <= size_is_wide(req_size);
            wbuf_q    <= req_wdata;
            hi_done_q <= 1'b0;
            rbuf_q    <= '0;
            phase_q   <= PH_MOVE;
          end
        end
        PH_MOVE: begin
          if (!op_wr_q) begin
            if (first_of_two) rbuf_q[15:8] <= rd_byte;
            else              rbuf_q[7:0]  <= rd_byte;
          end
          if (first_of_two) hi_done_q <= 1'b1;
          else              phase_q   <= PH_EVAL;
        end
        PH_EVAL: begin
          phase_q <= op_wr_q ? PH_IDLE : PH_REPLY;
        end
        PH_REPLY: begin
          if (rsp_ready) phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pdma_route.sv
`timescale 1ns/1ps
module pdma_route #(
  parameter int DAT_UW = 5,
  parameter int CMD_UW = 6
) (
  input  logic              mv_wr,
  input  logic              mv_rd,
  input  logic [7:0]        mv_byte,
  input  logic              cmd_mode,
  input  logic              tc_live,
  input  logic [7:0]        dat_head,
  input  logic [DAT_UW-1:0] dat_used,
  input  logic [DAT_UW-1:0] dat_free,
  input  logic [7:0]        cmd_head,
  input  logic [CMD_UW-1:0] cmd_used,
  input  logic [CMD_UW-1:0] cmd_free,
  output logic              dat_push,
  output logic              cmd_push,
  output logic [7:0]        push_byte,
  output logic              dat_pop,
  output logic              cmd_pop,
  output logic [7:0]        rd_byte
);

  logic room, avail, wr_go, rd_go;
  logic [7:0] head;

  always_comb begin
    room  = cmd_mode ? (cmd_free != '0) : (dat_free != '0);
    avail = cmd_mode ? (cmd_used != '0) : (dat_used != '0);
    head  = cmd_mode ? cmd_head : dat_head;
    // A byte is pushed only when the counter is live and the FIFO has room
    wr_go = mv_wr && tc_live && room;
    rd_go = mv_rd && avail;
    dat_push  = wr_go && !cmd_mode;
    cmd_push  = wr_go && cmd_mode;
    dat_pop   = rd_go && !cmd_mode;
    cmd_pop   = rd_go && cmd_mode;
    push_byte = mv_byte;
    rd_byte   = rd_go ? head : 8'h00;
  end

endmodule

// File: rtl/pdma_tcount.sv
`timescale 1ns/1ps
module pdma_tcount #(
  parameter int TC_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [TC_W-1:0] load_val,
  input  logic            dec,
  input  logic            flag_clr,
  output logic [TC_W-1:0] count,
  output logic            live,
  output logic            flag
);

  localparam logic [TC_W-1:0] ONE = TC_W'(1);

  assign live = (count != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      flag  <= 1'b0;
    end else begin
      if (load)             count <= load_val;
      else if (dec && live) count <= count - ONE;

      if (!load && dec && count == ONE) flag <= 1'b1;
      else if (flag_clr)                flag <= 1'b0;
    end
  end

endmodule

// File: rtl/pdma_burst.sv
`timescale 1ns/1ps
module pdma_burst #(
  parameter int DAT_UW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              at_eval,
  input  logic              eval_write,
  input  logic              tc_live,
  input  logic [DAT_UW-1:0] dat_used,
  input  logic [DAT_UW-1:0] dat_free,
  input  logic              drq_raise,
  input  logic              drq_lower,
  output logic              burst_done,
  output logic              drq
);

  localparam logic [DAT_UW-1:0] PAIR = DAT_UW'(2);

  logic wr_end, rd_end;

  // Both end tests look at the data FIFO whatever the routing
  assign wr_end     = !tc_live || (dat_free < PAIR);
  assign rd_end     = dat_used < PAIR;
  assign burst_done = at_eval && (eval_write ? wr_end : rd_end);

  always_ff @(posedge clk) begin
    if (!rst_n)                        drq <= 1'b0;
    else if (drq_raise)                drq <= 1'b1;
    else if (burst_done || drq_lower)  drq <= 1'b0;
  end

endmodule

// File: rtl/pdma_port.sv
`timescale 1ns/1ps
module pdma_port #(
  parameter int DAT_DEPTH = 16,
  parameter int CMD_DEPTH = 32,
  parameter int TC_W      = 24,
  localparam int DAT_UW   = $clog2(DAT_DEPTH + 1),
  localparam int CMD_UW   = $clog2(CMD_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [15:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [15:0]       rsp_data,
  input  logic              cmd_mode,
  output logic              dat_push,
  output logic              cmd_push,
  output logic [7:0]        push_byte,
  output logic              dat_pop,
  output logic              cmd_pop,
  input  logic [7:0]        dat_head,
  input  logic [DAT_UW-1:0] dat_used,
  input  logic [DAT_UW-1:0] dat_free,
  input  logic [7:0]        cmd_head,
  input  logic [CMD_UW-1:0] cmd_used,
  input  logic [CMD_UW-1:0] cmd_free,
  input  logic              tc_load,
  input  logic [TC_W-1:0]   tc_load_val,
  input  logic              tc_flag_clr,
  output logic [TC_W-1:0]   tc_count,
  output logic              tc_flag,
  input  logic              drq_raise,
  input  logic              drq_lower,
  output logic              drq,
  output logic              burst_done
);

  logic       mv_wr, mv_rd, at_eval, eval_write, tc_live;
  logic [7:0] mv_byte, rd_byte;

  pdma_seq u_seq (
    .clk, .rst_n,
    .req_valid, .req_ready, .req_write, .req_size, .req_wdata,
    .rsp_valid, .rsp_ready, .rsp_data,
    .mv_wr, .mv_rd, .mv_byte, .rd_byte,
    .at_eval, .eval_write
  );

  pdma_route #(.DAT_UW(DAT_UW), .CMD_UW(CMD_UW)) u_route (
    .mv_wr, .mv_rd, .mv_byte, .cmd_mode, .tc_live,
    .dat_head, .dat_used, .dat_free,
    .cmd_head, .cmd_used, .cmd_free,
    .dat_push, .cmd_push, .push_byte, .dat_pop, .cmd_pop, .rd_byte
  );

  pdma_tcount #(.TC_W(TC_W)) u_tc (
    .clk, .rst_n,
    .load     (tc_load),
    .load_val (tc_load_val),
    .dec      (mv_wr),
    .flag_clr (tc_flag_clr),
    .count    (tc_count),
    .live     (tc_live),
    .flag     (tc_flag)
  );

  pdma_burst #(.DAT_UW(DAT_UW)) u_burst (
    .clk, .rst_n, .at_eval, .eval_write, .tc_live,
    .dat_used, .dat_free, .drq_raise, .drq_lower,
    .burst_done, .drq
  );

endmodule

// File: rtl/pdma_port_chk.sv
`timescale 1ns/1ps
module pdma_port_chk #(
  parameter int DAT_UW = 5,
  parameter int CMD_UW = 6,
  parameter int TC_W   = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [15:0]       rsp_data,
  input logic              cmd_mode,
  input logic              dat_push,
  input logic              cmd_push,
  input logic              dat_pop,
  input logic              cmd_pop,
  input logic [DAT_UW-1:0] dat_used,
  input logic [DAT_UW-1:0] dat_free,
  input logic              tc_load,
  input logic [TC_W-1:0]   tc_count,
  input logic              tc_flag,
  input logic              drq_raise,
  input logic              drq,
  input logic              burst_done
);

  // R4
  no_push_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_push || cmd_push) |-> tc_count != '0);

  // R8
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dat_push && cmd_push) && !(dat_pop && cmd_pop));

  // R8
  cmd_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_push || cmd_pop) |-> cmd_mode);

  // R12
  no_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_pop |-> dat_used != '0);

  // R12
  no_full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_push |-> dat_free != '0);

  // R3
  tc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tc_load) |-> (tc_count == $past(tc_count) ||
                         tc_count == $past(tc_count) - TC_W'(1)));

  // R5
  tc_flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_count == '0 && $past(tc_count) == TC_W'(1) && !$past(tc_load)) |-> tc_flag);

  // R10
  drq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drq_raise |=> drq);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !burst_done);

  // R11
  reply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R11
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));

endmodule

bind pdma_port pdma_port_chk #(.DAT_UW(DAT_UW), .CMD_UW(CMD_UW), .TC_W(TC_W)) u_chk (.*);

// File: tb/sim_pdma_port.sv
`timescale 1ns/1ps
module sim_pdma_port;

  localparam int DAT_DEPTH = 16;
  localparam int CMD_DEPTH = 32;
  localparam int TC_W      = 24;
  localparam int DUW       = $clog2(DAT_DEPTH + 1);
  localparam int CUW       = $clog2(CMD_DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic req_valid = 0, req_write = 0, rsp_ready = 1, cmd_mode = 0;
  logic [1:0] req_size = 0;
  logic [15:0] req_wdata = 0;
  logic tc_load = 0, tc_flag_clr = 0, drq_raise = 0, drq_lower = 0;
  logic [TC_W-1:0] tc_load_val = 0;
  logic req_ready, rsp_valid, dat_push, cmd_push, dat_pop, cmd_pop;
  logic tc_flag, drq, burst_done;
  logic [15:0] rsp_data;
  logic [7:0] push_byte;
  logic [TC_W-1:0] tc_count;
  logic [7:0] dat_head = 0, cmd_head = 0;
  logic [DUW-1:0] dat_used = 0, dat_free = DUW'(DAT_DEPTH);
  logic [CUW-1:0] cmd_used = 0, cmd_free = CUW'(CMD_DEPTH);

  pdma_port #(.DAT_DEPTH(DAT_DEPTH), .CMD_DEPTH(CMD_DEPTH), .TC_W(TC_W)) u0 (.*);

  // External FIFOs driven by the design's strobes
  logic [7:0] bq_dat[$];
  logic [7:0] bq_cmd[$];
  always @(posedge clk) begin
    if (!rst_n) begin
      bq_dat.delete(); bq_cmd.delete();
    end else begin
      if (dat_push && bq_dat.size() < DAT_DEPTH) bq_dat.push_back(push_byte);
      if (cmd_push && bq_cmd.size() < CMD_DEPTH) bq_cmd.push_back(push_byte);
      if (dat_pop && bq_dat.size() > 0) void'(bq_dat.pop_front());
      if (cmd_pop && bq_cmd.size() > 0) void'(bq_cmd.pop_front());
    end
    dat_used <= DUW'(bq_dat.size());
    dat_free <= DUW'(DAT_DEPTH - bq_dat.size());
    dat_head <= (bq_dat.size() > 0) ? bq_dat[0] : 8'h00;
    cmd_used <= CUW'(bq_cmd.size());
    cmd_free <= CUW'(CMD_DEPTH - bq_cmd.size());
    cmd_head <= (bq_cmd.size() > 0) ? bq_cmd[0] : 8'h00;
  end

  // Reference model state
  int unsigned m_tc = 0;
  bit m_flag = 0, m_drq = 0, live = 0;
  logic [7:0] e_dat[$];
  logic [7:0] e_cmd[$];
  int n_cmp = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Compared on every clock
  always @(negedge clk) if (live) begin
    chk(tc_count == TC_W'(m_tc), "R3", tc_count, m_tc);
    chk(tc_flag == m_flag, "R5", tc_flag, m_flag);
    chk(drq == m_drq, "R10", drq, m_drq);
  end

  task automatic load_tc(input int unsigned v);
    tc_load = 1; tc_load_val = TC_W'(v);
    @(posedge clk); m_tc = v;
    @(negedge clk); tc_load = 0;
  endtask

  task automatic raise_drq();
    drq_raise = 1; @(posedge clk); m_drq = 1; @(negedge clk); drq_raise = 0;
  endtask

  task automatic lower_drq();
    drq_lower = 1; @(posedge clk); m_drq = 0; @(negedge clk); drq_lower = 0;
  endtask

  task automatic clr_flag();
    tc_flag_clr = 1; @(posedge clk); m_flag = 0; @(negedge clk); tc_flag_clr = 0;
  endtask

  task automatic eval_end(input bit exp_done, input string req);
    chk(burst_done == exp_done, req, burst_done, exp_done);
    @(posedge clk); if (exp_done) m_drq = 0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sz, input logic [15:0] v, input bit cmd);
    int nb = (sz != 2'd0) ? 2 : 1;
    chk(req_ready == 1'b1, "R11", req_ready, 1);
    req_valid = 1; req_write = 1; req_size = sz; req_wdata = v; cmd_mode = cmd;
    @(posedge clk); @(negedge clk); req_valid = 0;
    for (int b = 0; b < nb; b++) begin
      logic [7:0] bv = (nb == 2 && b == 0) ? v[15:8] : v[7:0];
      bit room = cmd ? (e_cmd.size() < CMD_DEPTH) : (e_dat.size() < DAT_DEPTH);
      bit exp_push = (m_tc != 0) && room;
      chk((cmd ? cmd_push : dat_push) == exp_push, (m_tc == 0) ? "R4" : "R12",
          cmd ? cmd_push : dat_push, exp_push);
      chk((cmd ? dat_push : cmd_push) == 1'b0, "R8", cmd ? dat_push : cmd_push, 0);
      if (exp_push) chk(push_byte == bv, (nb == 2) ? "R1" : "R9", push_byte, bv);
      @(posedge clk);
      if (m_tc != 0) begin
        if (room) begin if (cmd) e_cmd.push_back(bv); else e_dat.push_back(bv); end
        m_tc--;
        if (m_tc == 0) m_flag = 1;
      end
      @(negedge clk);
    end
    eval_end((m_tc == 0) || (DAT_DEPTH - e_dat.size() < 2), "R6");
  endtask

  task automatic rd(input logic [1:0] sz, input bit cmd, input int hold);
    int nb = (sz != 2'd0) ? 2 : 1;
    logic [15:0] ev = 16'h0000;
    chk(req_ready == 1'b1, "R11", req_ready, 1);
    req_valid = 1; req_write = 0; req_size = sz; cmd_mode = cmd;
    @(posedge clk); @(negedge clk); req_valid = 0;
    for (int b = 0; b < nb; b++) begin
      bit have = cmd ? (e_cmd.size() > 0) : (e_dat.size() > 0);
      logic [7:0] bv = 8'h00;
      if (have) bv = cmd ? e_cmd.pop_front() : e_dat.pop_front();
      chk((cmd ? cmd_pop : dat_pop) == have, "R12", cmd ? cmd_pop : dat_pop, have);
      chk((cmd ? dat_pop : cmd_pop) == 1'b0, "R8", cmd ? dat_pop : cmd_pop, 0);
      if (nb == 2 && b == 0) ev[15:8] = bv; else ev[7:0] = bv;
      @(posedge clk); @(negedge clk);
    end
    eval_end(e_dat.size() < 2, "R7");
    rsp_ready = (hold == 0);
    for (int h = 0; h < hold; h++) begin
      chk(rsp_valid && !req_ready, "R11", {rsp_valid, req_ready}, 2'b10);
      chk(rsp_data == ev, "R11", rsp_data, ev);
      @(posedge clk); @(negedge clk);
    end
    rsp_ready = 1;
    chk(rsp_valid == 1'b1, "R11", rsp_valid, 1);
    chk(rsp_data == ev, (nb == 2) ? "R2" : "R9", rsp_data, ev);
    @(posedge clk); @(negedge clk);
    chk(rsp_valid == 1'b0 && req_ready, "R11", rsp_valid, 0);
  endtask

  task automatic cmp_fifos();
    chk(bq_dat.size() == e_dat.size(), "R8", bq_dat.size(), e_dat.size());
    chk(bq_cmd.size() == e_cmd.size(), "R8", bq_cmd.size(), e_cmd.size());
    if (bq_dat.size() == e_dat.size())
      foreach (e_dat[i]) chk(bq_dat[i] == e_dat[i], "R1", bq_dat[i], e_dat[i]);
    if (bq_cmd.size() == e_cmd.size())
      foreach (e_cmd[i]) chk(bq_cmd[i] == e_cmd[i], "R8", bq_cmd[i], e_cmd[i]);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; live = 1;
    // reset state
    chk(req_ready && !rsp_valid && !burst_done, "R11", {req_ready, rsp_valid, burst_done}, 3'b100);
    chk(tc_count == 0 && !tc_flag && !drq, "R5", tc_count, 0);

    // R1 R3: wide and narrow writes
    load_tc(5); raise_drq();
    wr(2'd1, 16'hA1B2, 0);
    wr(2'd0, 16'hFF33, 0);
    wr(2'd1, 16'h4455, 0);          // counter reaches zero: R5 and R6
    cmp_fifos();
    // R4: write with the counter at zero is discarded
    wr(2'd0, 16'h0066, 0);
    cmp_fifos();
    clr_flag();

    // R2 R7 R9: reads drain the data FIFO
    raise_drq();
    rd(2'd1, 0, 0);
    rd(2'd0, 0, 0);
    rd(2'd1, 0, 0);
    raise_drq();
    rd(2'd1, 0, 0);                 // R12: empty FIFO gives 0x0000
    cmp_fifos();

    // R8: command FIFO routing
    load_tc(4); raise_drq();
    wr(2'd1, 16'h1122, 1);
    cmp_fifos();
    rd(2'd1, 1, 0);
    cmp_fifos();

    // R9: 4-byte access handled as 16 bits
    wr(2'd3, 16'hCAFE, 0);
    rd(2'd2, 0, 2);                 // R11: answer held without rsp_ready
    cmp_fifos();

    // R6 R12: fill the data FIFO, then overrun
    load_tc(100); raise_drq();
    for (int k = 0; k < 8; k++) wr(2'd1, 16'(16'h1000 + k * 16'h0203), 0);
    wr(2'd0, 16'h0099, 0);
    cmp_fifos();
    for (int k = 0; k < 8; k++) rd(2'd1, 0, 0);
    cmp_fifos();

    // R10: lower on request
    raise_drq(); lower_drq();
    @(negedge clk);
    summary();
  end

endmodule